// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

The block is a pulse accumulator with a count register (16 bits by default). In event mode it counts one chosen edge of an external pin. In gated mode it counts a divide-by-64 timebase, taken from the timer prescaler, while the pin sits at its active level. The pin passes through two synchronising flip-flops. All edge detection runs in the bus clock domain, and every derived clock is a single-cycle enable.

The block also chooses the clock enable for a separate free-running timer counter from four sources: the prescaler tick, the accumulator tick, the carry out of the count's low half, and the full-count wrap. At the default width these give full rate, /256 and /65536 of the accumulator clock. An overflow flag and an input flag serve as request outputs. Software clears them by writing ones to the flag register or, with fast clear enabled, by any access to the count register.

Register map (2-bit address): 0 = control, 1 = flags, 2 = count, 3 reads as zero. Control bits: bit 0 enables the accumulator, bits 2:1 hold the mode, bits 4:3 hold the timer clock select, bit 5 enables fast clear. The other control bits read as zero.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count, the flags and every control bit are zero. Reads of the control, flag and count registers and of address 3 return zero.
- R2: The mode values are 00 for falling edges and 01 for rising edges of the pin. With the accumulator enabled in one of these modes, each selected edge adds one to the count. The count shows the edge three clock edges after the pin changes.
- R3: Mode 10 counts div64_tick pulses while the synchronised pin is high. Mode 11 counts them while it is low. Ticks that arrive at the inactive level are not counted. When timer_en is low, gated mode does not count at all.
- R4: When the count wraps from all ones to zero, the overflow flag (flag bit 1, ovf_req) sets.
- R5: The input flag is flag bit 0 and drives edge_req. In event mode it sets on each selected edge. In gated mode it sets on the transition out of the active level, and not on the entry into it.
- R6: With the accumulator enabled, clock select 00 drives tcnt_tick from presc_tick. Select 01 gives one tcnt_tick per accumulator count. Select 10 gives one pulse per carry out of the low half of the count. Select 11 gives one pulse per full wrap. All of these are combinational, so a new select takes effect at once.
- R7: With the accumulator disabled, tcnt_tick follows presc_tick whatever the select field holds.
- R8: With fast clear off, writing 1 to a flag bit clears that flag and writing 0 leaves it. Flag bits above bit 1 read as zero.
- R9: With fast clear on, any read or write of the count register clears both flags, and writes to the flag register have no effect. If a flag sets in the same cycle as a clear, the set wins.
- R10: While timer_en and the accumulator enable are both low, every clear attempt is ignored.
- R11: A write to the count register loads it, and the write takes priority over an increment in the same cycle. With the accumulator disabled, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External accumulator pin (asynchronous) |
| timer_en | input | 1 | Timer enabled |
| presc_tick | input | 1 | Timer prescaler clock enable |
| div64_tick | input | 1 | Divide-by-64 tap of the timer prescaler |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data (combinational) |
| tcnt_tick | output | 1 | Clock enable for the timer counter |
| ovf_req | output | 1 | Overflow flag |
| edge_req | output | 1 | Input flag |

## Verification
The bench builds the block with CNT_W = 8. The low-half carry then comes every 16 counts and the full wrap every 256. Runs of 20 events from scattered preset values therefore cross both boundaries many times. The bench sweeps all four modes against all four clock selects and predicts the count, the overflow flag and the number of tcnt_tick pulses by arithmetic. Separate cases cover fast clear, clears while both enables are low, gated mode with the timer stopped, and the fallback to the prescaler.

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             timer_en,
  input  logic             presc_tick,
  input  logic             div64_tick,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             tcnt_tick,
  output logic             ovf_req,
  output logic             edge_req
);
  localparam int LO_W = CNT_W / 2;
  localparam logic [1:0] A_CTRL = 2'd0, A_FLAG = 2'd1, A_CNT = 2'd2;

  logic             acc_en, fast_clr;
  logic [1:0]       mode, clk_sel;
  logic [CNT_W-1:0] cnt;
  logic             ovf_flag, inp_flag;
  logic             pin_s1, pin_s2, pin_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {pin_s1, pin_s2, pin_d} <= '0;
    else        {pin_s1, pin_s2, pin_d} <= {pin_in, pin_s1, pin_s2};

  wire rise     = pin_s2 & ~pin_d;
  wire fall     = ~pin_s2 & pin_d;
  wire sel_edge = mode[0] ? rise : fall;
  wire gate_on  = pin_s2 ^ mode[0];
  wire acc_clk  = acc_en & (mode[1] ? (div64_tick & timer_en & gate_on) : sel_edge);
  wire lo_tick  = acc_clk & (&cnt[LO_W-1:0]);
  wire wrap     = acc_clk & (&cnt);

  wire cnt_wr   = reg_wr & (reg_addr == A_CNT);
  wire cnt_acc  = (reg_wr | reg_rd) & (reg_addr == A_CNT);
  wire clr_ok   = timer_en | acc_en;
  wire clr_all  = fast_clr & cnt_acc & clr_ok;
  wire w1c      = ~fast_clr & reg_wr & (reg_addr == A_FLAG) & clr_ok;
  wire inp_evt  = acc_en & sel_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {fast_clr, clk_sel, mode, acc_en} <= '0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      {fast_clr, clk_sel, mode, acc_en} <= reg_wdata[5:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (cnt_wr)  cnt <= reg_wdata;
    else if (acc_clk) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      inp_flag <= 1'b0;
    end else begin
      if (wrap)                         ovf_flag <= 1'b1;
      else if (clr_all || (w1c && reg_wdata[1])) ovf_flag <= 1'b0;
      if (inp_evt)                      inp_flag <= 1'b1;
      else if (clr_all || (w1c && reg_wdata[0])) inp_flag <= 1'b0;
    end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'({fast_clr, clk_sel, mode, acc_en});
      A_FLAG:  reg_rdata = CNT_W'({ovf_flag, inp_flag});
      A_CNT:   reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    if (!acc_en) tcnt_tick = presc_tick;
    else begin
      unique case (clk_sel)
        2'd0:    tcnt_tick = presc_tick;
        2'd1:    tcnt_tick = acc_clk;
        2'd2:    tcnt_tick = lo_tick;
        default: tcnt_tick = wrap;
      endcase
    end
  end

  assign ovf_req  = ovf_flag;
  assign edge_req = inp_flag;

  // R4
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cnt) == {CNT_W{1'b1}} && cnt == '0);
  // R3
  gate_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && mode[1] && !timer_en && !cnt_wr) |=> $stable(cnt));
  // R11
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !cnt_wr) |=> $stable(cnt));
  // R10
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en && !acc_en) |=> !$fell(ovf_flag) && !$fell(inp_flag));
  // R5
  inp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inp_flag) |-> $past(acc_en));
endmodule

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, pin_in = 0, timer_en = 1, presc_tick = 0, div64_tick = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;
  logic tcnt_tick, ovf_req, edge_req;
  int checks = 0, failures = 0, ticks = 0;
  bit done = 0;

  pulse_accum #(.CNT_W(W)) uut (.clk, .rst_n, .pin_in, .timer_en, .presc_tick, .div64_tick,
    .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata, .tcnt_tick, .ovf_req, .edge_req);

  always #4 clk = ~clk;
  always @(negedge clk) if (rst_n && tcnt_tick) ticks++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, int d);
    @(posedge clk); #1 reg_addr = a; reg_wdata = W'(d); reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    @(posedge clk); #1 reg_addr = a; reg_rd = 1;
    @(negedge clk); d = int'(reg_rdata);
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_d64();
    @(posedge clk); #1 div64_tick = 1;
    @(posedge clk); #1 div64_tick = 0;
  endtask

  task automatic pulse_presc();
    @(posedge clk); #1 presc_tick = 1;
    @(posedge clk); #1 presc_tick = 0;
  endtask

  int v;
  initial begin
    idle(2); rst_n = 1; idle(1);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 flags", v, 0);
    rd(2, v); chk("R1 count", v, 0);
    rd(3, v); chk("R1 addr3", v, 0);
    chk("R1 ovf_req", ovf_req, 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        int p, n, exp_t, wrapped;
        logic idl;
        p = (224 + 9 * (m * 4 + s)) % 256;
        n = 20;
        idl = ~(m[1] ^ m[0]);
        wr(0, 0);
        pin_in = idl; idle(5);
        wr(2, p);
        wr(1, 3);
        wr(0, 1 | (m << 1) | (s << 3));
        idle(1);
        chk("R8 flags cleared", int'(ovf_req) * 2 + int'(edge_req), 0);
        ticks = 0;
        if (m < 2) begin
          for (int k = 0; k < n; k++) begin
            pin_in = ~idl; idle(4);
            pin_in = idl;  idle(4);
          end
        end else begin
          repeat (3) pulse_d64();
          pin_in = ~idl; idle(4);
          for (int k = 0; k < n; k++) pulse_d64();
          idle(1);
          chk("R5 gated no flag on entry", edge_req, 0);
          pin_in = idl; idle(4);
        end
        exp_t = 0; wrapped = 0;
        for (int k = 0; k < n; k++) begin
          int c;
          c = (p + k) % 256;
          if (c == 255) wrapped = 1;
          if (s == 1) exp_t++;
          else if (s == 2 && (c % 16) == 15) exp_t++;
          else if (s == 3 && c == 255) exp_t++;
        end
        rd(2, v);
        chk(m < 2 ? "R2 edge count" : "R3 gated count", v, (p + n) % 256);
        chk("R4 overflow flag", ovf_req, wrapped);
        chk("R5 input flag", edge_req, 1);
        chk("R6 tcnt ticks", ticks, exp_t);
      end
    end

    // R6 select 00 with accumulator enabled
    wr(0, 1); ticks = 0;
    repeat (7) pulse_presc();
    idle(1); chk("R6 presc select", ticks, 7);
    // R7 fallback
    wr(0, 3 << 3); ticks = 0;
    repeat (5) pulse_presc();
    idle(1); chk("R7 fallback to prescaler", ticks, 5);

    // R8 W1C per bit, reserved bits zero
    wr(0, 1); pin_in = 1; idle(4);
    wr(2, 255);
    pin_in = 0; idle(4);
    rd(1, v); chk("R8 both flags set", v, 3);
    wr(1, 1); rd(1, v); chk("R8 clear inp only", v, 2);
    wr(1, 0); rd(1, v); chk("R8 zero write no effect", v, 2);
    wr(1, 2); rd(1, v); chk("R8 clear ovf", v, 0);

    // R9 fast clear
    wr(2, 255); pin_in = 1; idle(4); pin_in = 0; idle(4);
    wr(0, 1 | (1 << 5));
    wr(1, 3); rd(1, v); chk("R9 W1C ignored in fast mode", v, 3);
    rd(2, v); chk("R9 count after wrap", v, 0);
    rd(1, v); chk("R9 read clears flags", v, 0);
    wr(2, 255); pin_in = 1; idle(4); pin_in = 0; idle(4);
    rd(1, v); chk("R9 flags set again", v, 3);
    wr(2, 9); rd(1, v); chk("R9 write clears flags", v, 0);
    rd(2, v); chk("R11 count loaded", v, 9);

    // R10 clears ignored while both disabled
    wr(0, 1);
    wr(2, 255); pin_in = 1; idle(4); pin_in = 0; idle(4);
    wr(0, 0); timer_en = 0;
    wr(1, 3); rd(1, v); chk("R10 clear ignored", v, 3);
    timer_en = 1;
    wr(1, 3); rd(1, v); chk("R10 clear with timer on", v, 0);

    // R11 disabled count holds
    wr(2, 40); pin_in = 1; idle(4); pin_in = 0; idle(4);
    rd(2, v); chk("R11 disabled holds", v, 40);

    // R3 gated with timer disabled
    wr(0, 1 | (2 << 1)); pin_in = 1; idle(4);
    timer_en = 0;
    repeat (6) pulse_d64();
    timer_en = 1;
    rd(2, v); chk("R3 timer off no count", v, 40);
    pulse_d64();
    rd(2, v); chk("R3 timer on counts", v, 41);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule